// File: doc/BRIEF.md
# Binary Template Spectrotemporal Correlator

This block scores how well a streaming spectrogram matches a stored time-frequency pattern. A new frame of unsigned channel magnitudes, one per frequency bin, arrives on each cycle in which `frame_valid` is high. A one-bit-per-cell template picks the cells that count. Before summing, each selected cell takes its bin's magnitude minus the magnitude of the bin just below it. The lowest bin has no lower neighbour, so its neighbour counts as zero. The differencing is never applied to the input stream. It is carried out as a pair of non-negative sums, one for the bin's own magnitude and one for its lower neighbour, and the score is their difference.

A chain of accumulating stages holds the sums, one stage per template column. On every accepted frame, each stage adds its own column's contribution for that frame to the sum it receives from the stage before, then passes the result on. Stage 0 starts each frame from zero. The last stage therefore holds the score for the 64-frame window that ends at the newest frame: column 0 is applied to the oldest frame and column 63 to the newest. A small controller has two states. It starts in FILL. It moves to RUN on the edge that accepts the 64th frame since reset, and from then on it raises `score_valid`. RUN has no exit except reset. The template is loaded one column at a time through a write port that is only honoured between frames.

Top module: `spectro_corr`

## Requirements
- R1: After reset, `score_valid` is 0 and `score` is 0. Every template bit is 0.
- R2: The template is 64 columns by 16 bins. A write with `tpl_we`=1 replaces column `tpl_col` (0..63) with `tpl_bits`, where bit f selects bin f.
- R3: `frame_data` carries bin f as an unsigned 8-bit value in bits [8f+7:8f].
- R4: After the edge that accepts frame t, `score` equals the sum over k=0..63 and f=0..15 of T[k][f]·(x[f]−x[f−1]). Here x is frame t−63+k, x[−1]=0, and T[k] is the value column k had when that frame was accepted.
- R5: `score_valid` goes to 1 right after the edge that accepts the 64th frame since reset (FILL→RUN), and stays at 1 until the next reset.
- R6: `score` and `score_valid` change only on edges that accept a frame.
- R7: A template write presented while `frame_valid` is 1 is ignored.
- R8: A template write takes effect from the next accepted frame. Frames already in the window keep the contributions computed from the old template.
- R9: At full scale the score does not wrap. Every cell in a column selected with input 255 on even bins gives +130560, and the mirror case gives −130560.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_valid | input | 1 | Frame on `frame_data` is accepted this cycle |
| frame_data | input | 128 | 16 unsigned 8-bit bin magnitudes, bin 0 in the low byte |
| tpl_we | input | 1 | Template column write request |
| tpl_col | input | 6 | Template column to write |
| tpl_bits | input | 16 | New column bits, bit f selects bin f |
| score | output | 19 | Signed match score of the current window |
| score_valid | output | 1 | A full window has been accepted since reset |

## Verification
The assertions check four rules on every cycle. The valid flag agrees with an independent count of accepted frames, and it never falls. The score holds steady on cycles without a frame. The score stays within the full-scale bound. The numeric value of the score, the bin ordering, the timing of template writes against frames already in flight, and the rejection of writes during a frame can only be shown by the bench. Its behavioural model recomputes every window from the frame history and template snapshots, and it is compared on every clock.

// File: rtl/spectro_corr_pkg.sv
package spectro_corr_pkg;
    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } fill_state_e;
endpackage

// File: rtl/tpl_store.sv
module tpl_store #(
    parameter int T_COLS = 64,
    parameter int F_BINS = 16,
    localparam int COL_W = $clog2(T_COLS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [COL_W-1:0]         wr_col,
    input  logic [F_BINS-1:0]        wr_bits,
    output logic [T_COLS*F_BINS-1:0] tpl_flat
);
    genvar c;
    generate
        for (c = 0; c < T_COLS; c++) begin : g_col
            logic [F_BINS-1:0] col_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    col_q <= '0;
                end else if (wr_en && (wr_col == COL_W'(c))) begin
                    col_q <= wr_bits;
                end
            end
            assign tpl_flat[c*F_BINS +: F_BINS] = col_q;
        end
    endgenerate
endmodule

// File: rtl/corr_stage.sv
module corr_stage #(
    parameter int F_BINS = 16,
    parameter int SAMP_W = 8,
    parameter int ACC_W  = 18,
    parameter bit FIRST  = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [F_BINS-1:0]        col_bits,
    input  logic [F_BINS*SAMP_W-1:0] frame,
    input  logic [ACC_W-1:0]         pos_in,
    input  logic [ACC_W-1:0]         neg_in,
    output logic [ACC_W-1:0]         pos_out,
    output logic [ACC_W-1:0]         neg_out
);
    logic [ACC_W-1:0] own_sum;
    logic [ACC_W-1:0] nbr_sum;
    logic [ACC_W-1:0] pos_base;
    logic [ACC_W-1:0] neg_base;

    // own-bin magnitudes of selected cells
    always_comb begin
        own_sum = '0;
        for (int f = 0; f < F_BINS; f++) begin
            if (col_bits[f]) begin
                own_sum = own_sum + ACC_W'(frame[f*SAMP_W +: SAMP_W]);
            end
        end
    end

    // lower-neighbour magnitudes; bin 0 has none
    always_comb begin
        nbr_sum = '0;
        for (int f = 1; f < F_BINS; f++) begin
            if (col_bits[f]) begin
                nbr_sum = nbr_sum + ACC_W'(frame[(f-1)*SAMP_W +: SAMP_W]);
            end
        end
    end

    assign pos_base = FIRST ? '0 : pos_in;
    assign neg_base = FIRST ? '0 : neg_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_out <= '0;
            neg_out <= '0;
        end else if (en) begin
            pos_out <= pos_base + own_sum;
            neg_out <= neg_base + nbr_sum;
        end
    end
endmodule

// File: rtl/fill_ctrl.sv
module fill_ctrl
    import spectro_corr_pkg::*;
#(
    parameter int T_COLS = 64,
    localparam int CNT_W = $clog2(T_COLS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    output logic window_full
);
    fill_state_e      state_q, state_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        unique case (state_q)
            ST_FILL: begin
                if (accept) begin
                    if (cnt_q == CNT_W'(T_COLS-1)) begin
                        state_nx = ST_RUN;
                    end else begin
                        cnt_nx = cnt_q + 1'b1;
                    end
                end
            end
            ST_RUN: begin
                state_nx = ST_RUN;
            end
            default: state_nx = ST_FILL;
        endcase
    end

    always_comb begin
        window_full = 1'b0;
        unique case (state_q)
            ST_FILL: window_full = 1'b0;
            ST_RUN:  window_full = 1'b1;
            default: window_full = 1'b0;
        endcase
    end
endmodule

// File: rtl/spectro_corr.sv
module spectro_corr #(
    parameter int T_COLS = 64,
    parameter int F_BINS = 16,
    parameter int SAMP_W = 8,
    localparam int COL_W   = $clog2(T_COLS),
    localparam int ACC_W   = SAMP_W + $clog2(T_COLS*F_BINS),
    localparam int SCORE_W = ACC_W + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_valid,
    input  logic [F_BINS*SAMP_W-1:0]  frame_data,
    input  logic                      tpl_we,
    input  logic [COL_W-1:0]          tpl_col,
    input  logic [F_BINS-1:0]         tpl_bits,
    output logic signed [SCORE_W-1:0] score,
    output logic                      score_valid
);
    logic [T_COLS*F_BINS-1:0] tpl_flat;
    logic [ACC_W-1:0]         pos_chain [T_COLS+1];
    logic [ACC_W-1:0]         neg_chain [T_COLS+1];
    logic                     wr_ok;

    assign wr_ok = tpl_we & ~frame_valid;

    tpl_store #(.T_COLS(T_COLS), .F_BINS(F_BINS)) u_tpl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_ok),
        .wr_col   (tpl_col),
        .wr_bits  (tpl_bits),
        .tpl_flat (tpl_flat)
    );

    assign pos_chain[0] = '0;
    assign neg_chain[0] = '0;

    genvar s;
    generate
        for (s = 0; s < T_COLS; s++) begin : g_stage
            corr_stage #(
                .F_BINS (F_BINS),
                .SAMP_W (SAMP_W),
                .ACC_W  (ACC_W),
                .FIRST  (s == 0)
            ) u_stage (
                .clk      (clk),
                .rst_n    (rst_n),
                .en       (frame_valid),
                .col_bits (tpl_flat[s*F_BINS +: F_BINS]),
                .frame    (frame_data),
                .pos_in   (pos_chain[s]),
                .neg_in   (neg_chain[s]),
                .pos_out  (pos_chain[s+1]),
                .neg_out  (neg_chain[s+1])
            );
        end
    endgenerate

    fill_ctrl #(.T_COLS(T_COLS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (frame_valid),
        .window_full (score_valid)
    );

    assign score = $signed({1'b0, pos_chain[T_COLS]}) - $signed({1'b0, neg_chain[T_COLS]});
endmodule

// File: rtl/spectro_corr_chk.sv
module spectro_corr_chk #(
    parameter int T_COLS  = 64,
    parameter int F_BINS  = 16,
    parameter int SAMP_W  = 8,
    parameter int SCORE_W = 19
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      frame_valid,
    input logic signed [SCORE_W-1:0] score,
    input logic                      score_valid
);
    localparam int LIMIT = T_COLS * F_BINS * ((1 << SAMP_W) - 1);
    localparam int SEEN_W = $clog2(T_COLS + 1);

    logic [SEEN_W-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (frame_valid && (seen_q != SEEN_W'(T_COLS))) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    // R5
    valid_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        score_valid == (seen_q == SEEN_W'(T_COLS)));

    // R5
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        score_valid |=> score_valid);

    // R6
    score_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> $stable(score) && $stable(score_valid));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(score) <= LIMIT) && (int'(score) >= -LIMIT));
endmodule

bind spectro_corr spectro_corr_chk #(
    .T_COLS  (T_COLS),
    .F_BINS  (F_BINS),
    .SAMP_W  (SAMP_W),
    .SCORE_W (SCORE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .score       (score),
    .score_valid (score_valid)
);

// File: tb/spectro_corr_bench.sv
module spectro_corr_bench;
    localparam int CLK_PERIOD = 10;
    localparam int T  = 64;
    localparam int F  = 16;
    localparam int W  = 8;
    localparam int FW = F * W;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 frame_valid = 1'b0;
    logic [FW-1:0]        frame_data = '0;
    logic                 tpl_we = 1'b0;
    logic [5:0]           tpl_col = '0;
    logic [F-1:0]         tpl_bits = '0;
    logic signed [18:0]   score;
    logic                 score_valid;

    int  checks = 0;
    int  bad = 0;
    bit  tmpl [T][F];
    int  contrib [T][T];
    int  nacc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spectro_corr u_spectro_corr (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .frame_data  (frame_data),
        .tpl_we      (tpl_we),
        .tpl_col     (tpl_col),
        .tpl_bits    (tpl_bits),
        .score       (score),
        .score_valid (score_valid)
    );

    function automatic int expected_score();
        int acc = 0;
        for (int j = 0; j < T; j++) acc += contrib[(nacc - T + j) % T][j];
        return acc;
    endfunction

    task automatic check(string tag);
        checks++;
        if (score_valid !== (nacc >= T)) begin
            bad++;
            $display("FAIL %s score_valid actual=%0b expected=%0b", tag, score_valid, nacc >= T);
        end
        if (nacc >= T) begin
            checks++;
            if (int'(score) != expected_score()) begin
                bad++;
                $display("FAIL %s score actual=%0d expected=%0d", tag, int'(score), expected_score());
            end
        end
    endtask

    task automatic accept_frame(logic [FW-1:0] d);
        int slot = nacc % T;
        for (int k = 0; k < T; k++) begin
            int c = 0;
            for (int f = 0; f < F; f++) begin
                if (tmpl[k][f]) begin
                    c += int'(d[f*W +: W]);
                    if (f > 0) c -= int'(d[(f-1)*W +: W]);
                end
            end
            contrib[slot][k] = c;
        end
        nacc++;
    endtask

    task automatic step(bit fv, logic [FW-1:0] d, bit we, int col, logic [F-1:0] bits, string tag);
        @(negedge clk);
        check(tag);
        frame_valid = fv;
        frame_data  = d;
        tpl_we      = we;
        tpl_col     = 6'(col);
        tpl_bits    = bits;
        if (we && !fv) for (int f = 0; f < F; f++) tmpl[col][f] = bits[f];
        if (fv) accept_frame(d);
    endtask

    function automatic logic [FW-1:0] rand_frame();
        logic [FW-1:0] d;
        for (int f = 0; f < F; f++) d[f*W +: W] = 8'($urandom);
        return d;
    endfunction

    task automatic idle(string tag);
        step(1'b0, '0, 1'b0, 0, '0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        logic [FW-1:0] even_full;
        logic [FW-1:0] odd_full;
        void'($urandom(32'h5eed));
        for (int k = 0; k < T; k++) for (int f = 0; f < F; f++) tmpl[k][f] = 1'b0;
        even_full = '0;
        odd_full  = '0;
        for (int f = 0; f < F; f++) begin
            if (f % 2 == 0) even_full[f*W +: W] = 8'hff;
            else            odd_full[f*W +: W]  = 8'hff;
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        checks++;
        if (score_valid !== 1'b0 || score !== '0) begin
            bad++;
            $display("FAIL R1 reset actual=%0b/%0d expected=0/0", score_valid, int'(score));
        end

        // R2: load a random template column by column
        for (int k = 0; k < T; k++) step(1'b0, '0, 1'b1, k, 16'($urandom), "R2");

        // R5: fill, then R4 with random frames
        for (int i = 0; i < T; i++) step(1'b1, rand_frame(), 1'b0, 0, '0, "R5");
        for (int i = 0; i < 80; i++) step(1'b1, rand_frame(), 1'b0, 0, '0, "R4");

        // R3: one active bin per frame walks through all bins
        for (int i = 0; i < 70; i++) begin
            logic [FW-1:0] d = '0;
            d[(i % F)*W +: W] = 8'(i * 3 + 1);
            step(1'b1, d, 1'b0, 0, '0, "R3");
        end

        // R6: gaps between frames
        for (int i = 0; i < 40; i++) begin
            step(1'b1, rand_frame(), 1'b0, 0, '0, "R6");
            idle("R6");
            idle("R6");
        end

        // R7: writes during frames must be ignored
        for (int i = 0; i < 70; i++) step(1'b1, rand_frame(), 1'b1, i % T, 16'hffff, "R7");

        // R8: writes between frames take effect with the next frame
        for (int i = 0; i < 70; i++) begin
            step(1'b0, '0, 1'b1, $urandom % T, 16'($urandom), "R8");
            step(1'b1, rand_frame(), 1'b0, 0, '0, "R8");
        end

        // R9: full-scale positive, then negative
        for (int k = 0; k < T; k++) step(1'b0, '0, 1'b1, k, 16'h5555, "R9");
        for (int i = 0; i < T; i++) step(1'b1, even_full, 1'b0, 0, '0, "R9");
        idle("R9");
        checks++;
        if (int'(score) != 130560) begin
            bad++;
            $display("FAIL R9 positive actual=%0d expected=130560", int'(score));
        end
        for (int k = 0; k < T; k++) step(1'b0, '0, 1'b1, k, 16'haaaa, "R9");
        for (int i = 0; i < T; i++) step(1'b1, even_full, 1'b0, 0, '0, "R9");
        idle("R9");
        checks++;
        if (int'(score) != -130560) begin
            bad++;
            $display("FAIL R9 negative actual=%0d expected=-130560", int'(score));
        end
        for (int i = 0; i < T; i++) step(1'b1, odd_full, 1'b0, 0, '0, "R9");
        idle("R9");

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule